// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block sits between a simple word-addressed register bus and an 8-input, 10-bit successive-approximation converter. Software sets the input channel and the conversion mode, switches the converter on, and requests a conversion through a start bit. The block issues the start pulse only after the converter has had time to settle following power-up. It then waits for the converter's done strobe and captures the result. Alongside the result it stores the channel that was actually launched, so software can confirm that the value belongs to the channel it asked for.

Reads are combinational: `bus_rdata` shows the addressed register while `bus_rd` is high and zero otherwise. Writes take effect at the clock edge that ends the strobe cycle. Address bits [1:0] are ignored.

A five-state machine drives the converter. **OFF** is the powered-down state. **WARM** counts the settling window. **IDLE** is ready and waits for a start request. **LAUNCH** drives the one-cycle start pulse. **BUSY** waits for the done strobe. The transitions are:
- *power-on*: OFF to WARM.
- *settled*: WARM to IDLE after `WAIT_CYC` cycles.
- *request*: IDLE to LAUNCH when the start bit is set.
- *issued*: LAUNCH to BUSY.
- *complete*: BUSY to IDLE on done.
- *power-off*: any state to OFF when the power bit is cleared.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset every register reads 0, `cnv_pwr` is 0 and `cnv_start` is 0.
- R2: The register at word offset 0x00 holds the channel in bits [2:0], the start bit in bit 4 and the single-shot select in bit 5 (1 = single, 0 = repeating). Bit 0 of 0x10 powers the converter on when set. 0x14 is a 32-bit read/write scratch register. Unmapped offsets read 0.
- R3: While the power bit is 0, a start request is ignored: the start bit reads 0, no start pulse is issued and 0x08 is unchanged. Clearing the power bit also drops a pending start and abandons a running conversion, which then sets neither the flag nor the count.
- R4: `cnv_start` never rises until `cnv_pwr` has been high for at least `WAIT_CYC` (8) clock cycles. A start requested earlier is held pending and is issued once that window has passed.
- R5: Each launch is a single-cycle `cnv_start` pulse, with `cnv_chan` equal to the channel field at the moment of launch.
- R6: The end-of-conversion flag (bit 0 of 0x08) clears when a conversion is launched. On the cycle it sets, the result register (0x04, bits [9:0], upper bits read 0) and the sampled-channel register (0x0C, bits [2:0]) update together.
- R7: In single-shot mode the start bit clears itself once the conversion has been launched, so exactly one conversion runs.
- R8: In repeating mode, conversions follow one another for as long as the start bit stays 1.
- R9: The count register (0x20, bits [15:0]) increments once for each completed conversion.
- R10: Rewriting the channel field during a conversion does not change the channel that is reported for that conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 6 | Byte address (word aligned) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero when not reading |
| cnv_pwr | output | 1 | Converter power enable |
| cnv_chan | output | 3 | Channel presented to the converter |
| cnv_start | output | 1 | One-cycle start pulse |
| cnv_done | input | 1 | Conversion-finished strobe from the converter |
| cnv_result | input | 10 | Converter result, valid with `cnv_done` |

## Verification
On every cycle, the assertions check the following:
- the settling window before any start pulse;
- the single-cycle width of the start pulse;
- the cleared flag at launch;
- the rule that the flag, result and count move only in step with a done strobe;
- the dropping of the start bit while powered down;
- the self-clearing of the start bit in single-shot mode.

Only the bench scenarios can show the other behaviours, because each of them needs a full sequence of bus traffic against a converter model. These behaviours are: that a request made during warm-up is honoured later, that the reported channel survives a mid-conversion rewrite, that repeating mode keeps launching and stops once the start bit is cleared, and that an abandoned conversion leaves the flag and the count untouched.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    typedef enum logic [2:0] {
        S_OFF    = 3'd0,
        S_WARM   = 3'd1,
        S_IDLE   = 3'd2,
        S_LAUNCH = 3'd3,
        S_BUSY   = 3'd4
    } seq_state_t;

    // word offsets (byte address >> 2)
    localparam logic [3:0] W_CFG   = 4'h0;
    localparam logic [3:0] W_DATA  = 4'h1;
    localparam logic [3:0] W_EOC   = 4'h2;
    localparam logic [3:0] W_SAMP  = 4'h3;
    localparam logic [3:0] W_PWR   = 4'h4;
    localparam logic [3:0] W_DBG   = 4'h5;
    localparam logic [3:0] W_COUNT = 4'h8;

    localparam int CFG_START_BIT  = 4;
    localparam int CFG_SINGLE_BIT = 5;
endpackage

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
    import adc_seq_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32,
    parameter int CH_W   = 3,
    parameter int RES_W  = 10,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              launch_i,
    input  logic              eoc_i,
    input  logic [RES_W-1:0]  data_i,
    input  logic [CH_W-1:0]   samp_i,
    input  logic [CNT_W-1:0]  count_i,
    output logic [CH_W-1:0]   cfg_chan_o,
    output logic              cfg_start_o,
    output logic              pwr_on_o
);
    localparam int WSEL_W = ADDR_W - 2;

    logic [WSEL_W-1:0] wsel;
    logic [CH_W-1:0]   chan_q;
    logic              start_q;
    logic              single_q;
    logic              pwr_q;
    logic [DATA_W-1:0] dbg_q;
    logic              wr_cfg;

    assign wsel   = bus_addr[ADDR_W-1:2];
    assign wr_cfg = bus_wr && (wsel == WSEL_W'(W_CFG));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan_q   <= '0;
            start_q  <= 1'b0;
            single_q <= 1'b0;
            pwr_q    <= 1'b0;
            dbg_q    <= '0;
        end else begin
            if (wr_cfg) begin
                chan_q   <= bus_wdata[CH_W-1:0];
                single_q <= bus_wdata[CFG_SINGLE_BIT];
                start_q  <= bus_wdata[CFG_START_BIT];
            end else if (launch_i && single_q) begin
                start_q <= 1'b0;
            end
            if (bus_wr && (wsel == WSEL_W'(W_PWR)))
                pwr_q <= bus_wdata[0];
            if (bus_wr && (wsel == WSEL_W'(W_DBG)))
                dbg_q <= bus_wdata;
            // a powered-down converter cannot hold a start request
            if (!pwr_q)
                start_q <= 1'b0;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            unique case (wsel)
                WSEL_W'(W_CFG): begin
                    bus_rdata[CH_W-1:0]       = chan_q;
                    bus_rdata[CFG_START_BIT]  = start_q;
                    bus_rdata[CFG_SINGLE_BIT] = single_q;
                end
                WSEL_W'(W_DATA):  bus_rdata[RES_W-1:0] = data_i;
                WSEL_W'(W_EOC):   bus_rdata[0]         = eoc_i;
                WSEL_W'(W_SAMP):  bus_rdata[CH_W-1:0]  = samp_i;
                WSEL_W'(W_PWR):   bus_rdata[0]         = pwr_q;
                WSEL_W'(W_DBG):   bus_rdata            = dbg_q;
                WSEL_W'(W_COUNT): bus_rdata[CNT_W-1:0] = count_i;
                default:          bus_rdata            = '0;
            endcase
        end
    end

    assign cfg_chan_o  = chan_q;
    assign cfg_start_o = start_q;
    assign pwr_on_o    = pwr_q;

    AST_START_DROPPED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_q |=> !start_q); // R3
    AST_SINGLE_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (launch_i && single_q && !wr_cfg) |=> !start_q); // R7
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int CH_W     = 3,
    parameter int RES_W    = 10,
    parameter int CNT_W    = 16,
    parameter int WAIT_CYC = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_on,
    input  logic             start_req,
    input  logic [CH_W-1:0]  cfg_chan,
    input  logic             cnv_done,
    input  logic [RES_W-1:0] cnv_result,
    output logic             cnv_start,
    output logic [CH_W-1:0]  cnv_chan,
    output logic             launch_o,
    output logic             eoc_o,
    output logic [RES_W-1:0] data_o,
    output logic [CH_W-1:0]  samp_o,
    output logic [CNT_W-1:0] count_o
);
    localparam int WCNT_W = $clog2(WAIT_CYC + 1) + 1;

    seq_state_t        state_q, state_d;
    logic [WCNT_W-1:0] warm_q;
    logic [CH_W-1:0]   chan_q;
    logic              eoc_q;
    logic [RES_W-1:0]  data_q;
    logic [CH_W-1:0]   samp_q;
    logic [CNT_W-1:0]  cnt_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_OFF;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_OFF:    if (pwr_on) state_d = S_WARM;
            S_WARM:   if (!pwr_on) state_d = S_OFF;
                      else if (warm_q == WCNT_W'(WAIT_CYC - 1)) state_d = S_IDLE;
            S_IDLE:   if (!pwr_on) state_d = S_OFF;
                      else if (start_req) state_d = S_LAUNCH;
            S_LAUNCH: if (!pwr_on) state_d = S_OFF;
                      else state_d = S_BUSY;
            S_BUSY:   if (!pwr_on) state_d = S_OFF;
                      else if (cnv_done) state_d = S_IDLE;
            default:  state_d = S_OFF;
        endcase
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            warm_q <= '0;
            chan_q <= '0;
            eoc_q  <= 1'b0;
            data_q <= '0;
            samp_q <= '0;
            cnt_q  <= '0;
        end else begin
            warm_q <= (state_q == S_WARM) ? warm_q + 1'b1 : '0;
            if (state_q == S_IDLE && state_d == S_LAUNCH) begin
                chan_q <= cfg_chan;
                eoc_q  <= 1'b0;
            end
            if (state_q == S_BUSY && state_d == S_IDLE) begin
                eoc_q  <= 1'b1;
                data_q <= cnv_result;
                samp_q <= chan_q;
                cnt_q  <= cnt_q + 1'b1;
            end
        end
    end

    assign cnv_start = (state_q == S_LAUNCH) && pwr_on;
    assign cnv_chan  = chan_q;
    assign launch_o  = (state_q == S_LAUNCH);
    assign eoc_o     = eoc_q;
    assign data_o    = data_q;
    assign samp_o    = samp_q;
    assign count_o   = cnt_q;

    // cycles since converter power rose, saturating
    logic [WCNT_W-1:0] pwr_age;
    always_ff @(posedge clk) begin
        if (!rst_n || !pwr_on)            pwr_age <= '0;
        else if (pwr_age < WCNT_W'(WAIT_CYC)) pwr_age <= pwr_age + 1'b1;
    end

    AST_START_AFTER_WARM: assert property (@(posedge clk) disable iff (!rst_n)
        cnv_start |-> (pwr_age >= WCNT_W'(WAIT_CYC))); // R4
    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        cnv_start |=> !cnv_start); // R5
    AST_EOC_CLEAR_AT_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        cnv_start |-> !eoc_q); // R6
    AST_EOC_FROM_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eoc_q) |-> $past(cnv_done)); // R6
    AST_DATA_WITH_EOC: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(data_q) |-> $rose(eoc_q)); // R6
    AST_COUNT_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cnt_q) |-> ($past(cnv_done) && $rose(eoc_q))); // R9
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int ADDR_W   = 6,
    parameter int DATA_W   = 32,
    parameter int CH_W     = 3,
    parameter int RES_W    = 10,
    parameter int CNT_W    = 16,
    parameter int WAIT_CYC = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              cnv_pwr,
    output logic [CH_W-1:0]   cnv_chan,
    output logic              cnv_start,
    input  logic              cnv_done,
    input  logic [RES_W-1:0]  cnv_result
);
    logic             launch;
    logic             eoc;
    logic [RES_W-1:0] data;
    logic [CH_W-1:0]  samp;
    logic [CNT_W-1:0] count;
    logic [CH_W-1:0]  cfg_chan;
    logic             cfg_start;
    logic             pwr_on;

    adc_seq_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CH_W(CH_W),
        .RES_W(RES_W), .CNT_W(CNT_W)
    ) i_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .launch_i(launch), .eoc_i(eoc), .data_i(data),
        .samp_i(samp), .count_i(count),
        .cfg_chan_o(cfg_chan), .cfg_start_o(cfg_start), .pwr_on_o(pwr_on)
    );

    adc_seq_fsm #(
        .CH_W(CH_W), .RES_W(RES_W), .CNT_W(CNT_W), .WAIT_CYC(WAIT_CYC)
    ) i_fsm (
        .clk(clk), .rst_n(rst_n),
        .pwr_on(pwr_on), .start_req(cfg_start), .cfg_chan(cfg_chan),
        .cnv_done(cnv_done), .cnv_result(cnv_result),
        .cnv_start(cnv_start), .cnv_chan(cnv_chan), .launch_o(launch),
        .eoc_o(eoc), .data_o(data), .samp_o(samp), .count_o(count)
    );

    assign cnv_pwr = pwr_on;
endmodule

// File: tb/test_adc_seq_ctrl.sv
module test_adc_seq_ctrl;
    localparam int LAT = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        cnv_pwr;
    logic [2:0]  cnv_chan;
    logic        cnv_start;
    logic        cnv_done = 1'b0;
    logic [9:0]  cnv_result = '0;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // model and monitor state
    int       n_starts = 0;
    int       n_dones = 0;
    logic [2:0] m_chan = '0;
    logic [9:0] m_last = '0;
    int       pwr_age = 0;
    int       last_gap = 0;
    int       wide_start = 0;
    bit       prev_start = 0;

    always #10 clk = ~clk; // 50 MHz

    adc_seq_ctrl i_adc_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cnv_pwr(cnv_pwr), .cnv_chan(cnv_chan), .cnv_start(cnv_start),
        .cnv_done(cnv_done), .cnv_result(cnv_result)
    );

    function automatic logic [9:0] res_of(input logic [2:0] ch, input int n);
        return 10'((int'(ch) * 97 + n * 13 + 5) % 1024);
    endfunction

    function automatic logic [31:0] cfg(input logic [2:0] ch, input bit st, input bit sg);
        return {26'b0, sg, st, 1'b0, ch};
    endfunction

    // converter model
    initial begin
        forever begin
            @(negedge clk);
            if (cnv_start) begin
                m_chan = cnv_chan;
                n_starts++;
                repeat (LAT) @(negedge clk);
                cnv_result = res_of(m_chan, n_starts);
                m_last = cnv_result;
                cnv_done = 1'b1;
                n_dones++;
                @(negedge clk);
                cnv_done = 1'b0;
            end
        end
    end

    // monitor: power age at start, pulse width
    initial begin
        forever begin
            @(negedge clk);
            if (!cnv_pwr) pwr_age = 0; else pwr_age++;
            if (cnv_start) last_gap = pwr_age;
            if (cnv_start && prev_start) wide_start++;
            prev_start = cnv_start;
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic wait_eoc();
        logic [31:0] v;
        for (int i = 0; i < 60; i++) begin
            rd(6'h08, v);
            if (v[0]) break;
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(6'h00, v); chk("R1", "config after reset", v, 0);
        rd(6'h08, v); chk("R1", "eoc after reset", v, 0);
        rd(6'h04, v); chk("R1", "data after reset", v, 0);
        rd(6'h20, v); chk("R1", "count after reset", v, 0);
        chk("R1", "cnv_pwr after reset", {31'b0, cnv_pwr}, 0);
        chk("R1", "cnv_start after reset", {31'b0, cnv_start}, 0);
    endtask

    task automatic t_map();
        logic [31:0] v;
        wr(6'h14, 32'hA5C3_0F96);
        rd(6'h14, v); chk("R2", "scratch readback", v, 32'hA5C3_0F96);
        rd(6'h18, v); chk("R2", "unmapped reads zero", v, 0);
        wr(6'h00, cfg(3'd5, 1'b0, 1'b1));
        rd(6'h00, v); chk("R2", "config fields", v, 32'h25);
    endtask

    task automatic t_start_off();
        logic [31:0] v;
        wr(6'h00, cfg(3'd2, 1'b1, 1'b1));
        repeat (20) @(negedge clk);
        rd(6'h00, v); chk("R3", "start bit while off", {31'b0, v[4]}, 0);
        chk("R3", "no start pulse while off", n_starts, 0);
        rd(6'h08, v); chk("R3", "eoc untouched while off", v, 0);
    endtask

    task automatic t_warm_single();
        logic [31:0] v;
        wr(6'h10, 32'h1);
        wr(6'h00, cfg(3'd3, 1'b1, 1'b1)); // request during warm-up
        wait_eoc();
        chk("R4", "pending start issued", n_starts, 1);
        // age counts the sampled cycles with power high; >8 means 8 full cycles passed
        chk("R4", "warm window kept", {31'b0, last_gap > 8}, 1);
        chk("R5", "start pulse single cycle", wide_start, 0);
        rd(6'h04, v); chk("R6", "result value", v, {22'b0, res_of(3'd3, 1)});
        rd(6'h0C, v); chk("R6", "sampled channel", v, 3);
        rd(6'h00, v); chk("R7", "start bit self cleared", {31'b0, v[4]}, 0);
        repeat (15) @(negedge clk);
        chk("R7", "only one conversion", n_starts, 1);
        rd(6'h20, v); chk("R9", "count after one", v, 1);
    endtask

    task automatic t_chan_change();
        logic [31:0] v;
        wr(6'h00, cfg(3'd6, 1'b1, 1'b1));
        rd(6'h08, v); chk("R6", "eoc cleared on launch", v, 0);
        wr(6'h00, cfg(3'd1, 1'b0, 1'b1)); // rewrite channel while busy
        wait_eoc();
        rd(6'h0C, v); chk("R10", "sampled keeps launched channel", v, 6);
        rd(6'h04, v); chk("R6", "result for channel 6", v[9:0], res_of(3'd6, n_starts));
        chk("R6", "result upper bits zero", {10'b0, v[31:10]}, 0);
        rd(6'h20, v); chk("R9", "count after two", v, 2);
    endtask

    task automatic t_repeat();
        logic [31:0] v;
        int s0;
        s0 = n_starts;
        wr(6'h00, cfg(3'd2, 1'b1, 1'b0));
        for (int i = 0; i < 200; i++) begin
            rd(6'h20, v);
            if (v >= 5) break;
        end
        chk("R8", "repeating reached count", {31'b0, v >= 5}, 1);
        wr(6'h00, cfg(3'd2, 1'b0, 1'b0));
        repeat (20) @(negedge clk);
        chk("R8", "several launches", {31'b0, (n_starts - s0) >= 3}, 1);
        rd(6'h20, v); chk("R9", "count equals completions", v, n_dones);
        rd(6'h04, v); chk("R8", "last result", v, {22'b0, m_last});
        rd(6'h0C, v); chk("R8", "repeat channel", v, 2);
        s0 = n_starts;
        repeat (20) @(negedge clk);
        chk("R8", "stops after start cleared", n_starts, s0);
    endtask

    task automatic t_power_abort();
        logic [31:0] v;
        logic [31:0] c0;
        rd(6'h20, c0);
        wr(6'h00, cfg(3'd4, 1'b1, 1'b1));
        repeat (2) @(negedge clk);
        wr(6'h10, 32'h0); // abandon running conversion
        repeat (15) @(negedge clk);
        rd(6'h08, v); chk("R3", "abort leaves eoc clear", v, 0);
        rd(6'h20, v); chk("R3", "abort leaves count", v, c0);
        chk("R3", "power output low", {31'b0, cnv_pwr}, 0);
        rd(6'h00, v); chk("R3", "pending start dropped", {31'b0, v[4]}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_map();
        t_start_off();
        t_warm_single();
        t_chan_change();
        t_repeat();
        t_power_abort();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule